// File: doc/BRIEF.md
# Multi-Channel Button Debouncer

This block cleans up a bank of independent mechanical contact inputs that arrive with no timing relation to the system clock. Each channel first goes through its own two-stage synchronizer. It then drives a settled output that follows the synchronized level only after that level has stayed unchanged for a fixed interval. Every channel has its own timer, so contact chatter on one input never holds back or swallows a clean transition on another.

Two timing variants are selectable by parameter. In the power-of-two variant, an up-counter is cleared whenever the two synchronizer stages disagree, counts while its top bit is clear, and lets the output copy the older stage once that bit is set. In the time-based variant, a down-counter is preloaded from a settle time in microseconds and a clock period in nanoseconds. It decrements while the synchronized level differs from the output, and the output is loaded when the counter goes negative.

Top module: `debounce_bank`

## Requirements
- R1: While reset is asserted, and after its release until a channel has settled on a new level, every output bit is 0.
- R2: An output bit only changes to a value that the input held, unchanged, at the second and third sampling edges before that change. This is the two-flip-flop synchronizer path.
- R3: In the power-of-two variant, a clean input change applied to a settled channel appears at the output exactly 2^CNT_MSB + 3 rising clock edges later. This holds for both rising and falling inputs.
- R4: In the power-of-two variant, an input pulse shorter than 2^CNT_MSB clock cycles leaves the output unchanged.
- R5: Any change between the synchronizer stages restarts the channel's timer. After a burst of chatter, the output follows the final level exactly 2^CNT_MSB + 3 edges after the last input change.
- R6: Channels are independent. A channel that keeps chattering neither delays nor suppresses a clean change on another channel.
- R7: In the time-based variant, the preload value is SETTLE_US*1000/CLK_PERIOD_NS - 3. A clean change reaches the output exactly preload + 4 rising edges after it is applied, in both directions.
- R8: In the time-based variant, an input that returns to the output's level before the timer expires reloads the timer. The full interval is then measured again from the next departure.
- R9: An output bit never changes on two consecutive clock edges.
- R10: The outputs never carry unknown values once reset has been applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn_i | input | NUM_CH | Raw asynchronous contact inputs |
| btn_o | output | NUM_CH | Settled levels, one per channel |

## Verification
The hardest case to reach from the ports is a clean transition on one channel while its neighbour is being hit with chatter in the very same cycles. Only that case shows whether the timers share any state. The stimulus toggles one input every four cycles for the whole settle window of another channel, which steps cleanly at the start of that window. It then checks the clean channel on the exact edge its settle interval ends and checks that the chattering channel never moved. A second hard case is a time-based channel that drifts back to its output level just before expiry. It is reached by holding the new level for about half the interval, returning briefly, and then timing the full interval again from the final departure.

// File: rtl/db_pkg.sv
package db_pkg;

  typedef enum logic {
    DB_POW2 = 1'b0,
    DB_TIMED = 1'b1
  } db_mode_e;

  // Preload for the time-based timer; the three cycles cover sync and load.
  function automatic int unsigned timed_preload(input int unsigned settle_us,
                                                input int unsigned period_ns);
    return (settle_us * 1000) / period_ns - 3;
  endfunction

endpackage

// File: rtl/db_sync.sv
module db_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] stg1_o,
  output logic [W-1:0] stg2_o
);

  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign stg1_o = stg1_q;
  assign stg2_o = stg2_q;

endmodule

// File: rtl/db_pow2_timer.sv
module db_pow2_timer #(
  parameter int unsigned CNT_MSB = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic new_i,
  input  logic old_i,
  output logic lvl_o
);

  localparam int unsigned CW = CNT_MSB + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          cnt_en, lvl_en;

  always_comb begin
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    cnt_en = 1'b0;
    lvl_en = 1'b0;
    if (new_i ^ old_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (!cnt_q[CNT_MSB]) begin
      cnt_d  = cnt_q + CW'(1);
      cnt_en = 1'b1;
    end else begin
      lvl_d  = old_i;
      lvl_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (lvl_en) lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/db_timed_timer.sv
module db_timed_timer #(
  parameter int unsigned PRELOAD = 149997,
  parameter int unsigned CW      = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic new_i,
  input  logic old_i,
  output logic lvl_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          lvl_en;

  // Counts down only while both stages agree on a level that differs
  // from the output; any other situation reloads the full interval.
  always_comb begin
    lvl_d  = lvl_q;
    lvl_en = 1'b0;
    cnt_d  = CW'(PRELOAD);
    if (cnt_q[CW-1]) begin
      lvl_d  = old_i;
      lvl_en = 1'b1;
    end else if ((new_i == old_i) && (old_i != lvl_q)) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(PRELOAD);
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (lvl_en) lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/debounce_bank.sv
module debounce_bank #(
  parameter int unsigned      NUM_CH        = 4,
  parameter db_pkg::db_mode_e MODE          = db_pkg::DB_POW2,
  parameter int unsigned      CNT_MSB       = 19,
  parameter int unsigned      CLK_PERIOD_NS = 20,
  parameter int unsigned      SETTLE_US     = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] btn_i,
  output logic [NUM_CH-1:0] btn_o
);

  localparam int unsigned PRELOAD = db_pkg::timed_preload(SETTLE_US, CLK_PERIOD_NS);
  localparam int unsigned TCW     = $clog2(PRELOAD + 1) + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NUM_CH-1:0] stg1, stg2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  db_sync #(.W(NUM_CH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .d_i    (btn_i),
    .stg1_o (stg1),
    .stg2_o (stg2)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    if (MODE == db_pkg::DB_POW2) begin : g_pow2
      db_pow2_timer #(.CNT_MSB(CNT_MSB)) u_tmr (
        .clk   (clk),
        .rst_n (rst_int_n),
        .new_i (stg1[ch]),
        .old_i (stg2[ch]),
        .lvl_o (btn_o[ch])
      );
    end else begin : g_timed
      db_timed_timer #(.PRELOAD(PRELOAD), .CW(TCW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_int_n),
        .new_i (stg1[ch]),
        .old_i (stg2[ch]),
        .lvl_o (btn_o[ch])
      );
    end
  end

endmodule

// File: rtl/db_bank_chk.sv
module db_bank_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] btn_i,
  input logic [NUM_CH-1:0] btn_o
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_ZERO: assert (btn_o == '0);  // R1
    end
  end

  AST_NO_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(btn_o));  // R10

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    AST_SYNCED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(btn_o[ch]) |-> (btn_o[ch] == $past(btn_i[ch], 2)) &&
                              ($past(btn_i[ch], 2) == $past(btn_i[ch], 3)));  // R2

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(btn_o[ch]) |=> $stable(btn_o[ch]));  // R9
  end

endmodule

bind debounce_bank db_bank_chk #(.NUM_CH(NUM_CH)) u_db_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .btn_i (btn_i),
  .btn_o (btn_o)
);

// File: tb/tb_debounce_bank.sv
module tb_debounce_bank;

  localparam int unsigned MSB   = 4;
  localparam int unsigned LAT_P = (1 << MSB) + 3;        // 19 edges
  localparam int unsigned PER   = 10;
  localparam int unsigned US    = 1;
  localparam int unsigned PRE   = US * 1000 / PER - 3;   // 97
  localparam int unsigned LAT_T = PRE + 4;               // 101 edges

  logic       clk;
  logic       rst_n;
  logic [3:0] btn_p, out_p;
  logic [1:0] btn_t, out_t;

  int checks = 0;
  int errors = 0;

  debounce_bank #(.NUM_CH(4), .MODE(db_pkg::DB_POW2), .CNT_MSB(MSB)) dut (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_p), .btn_o(out_p));

  debounce_bank #(.NUM_CH(2), .MODE(db_pkg::DB_TIMED), .CLK_PERIOD_NS(PER),
                  .SETTLE_US(US)) dut_tm (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_t), .btn_o(out_t));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset pow2", |out_p, 1'b0);
    chk("R1 reset timed", |out_t, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    cyc(10);
    chk("R1 after release pow2", |out_p, 1'b0);
    chk("R1 after release timed", |out_t, 1'b0);
  endtask

  // Clean step on one pow2 channel: old value on edge LAT_P-1, new on LAT_P.
  task automatic t_step(input int ch, input logic val);
    cyc(LAT_P + 5);
    btn_p[ch] = val;
    cyc(LAT_P - 1);
    chk("R2 R3 pow2 not yet", out_p[ch], ~val);
    cyc(1);
    chk("R3 pow2 settled", out_p[ch], val);
    cyc(3);
    chk("R9 pow2 holds", out_p[ch], val);
  endtask

  task automatic t_short_pulse();
    logic moved = 1'b0;
    cyc(LAT_P + 5);
    btn_p[1] = 1'b1;
    cyc(10);
    btn_p[1] = 1'b0;
    for (int k = 0; k < 3 * LAT_P; k++) begin
      cyc(1);
      if (out_p[1] !== 1'b0) moved = 1'b1;
    end
    chk("R4 short pulse ignored", moved, 1'b0);
  endtask

  task automatic t_bounce();
    logic moved = 1'b0;
    cyc(LAT_P + 5);
    for (int k = 0; k < 9; k++) begin
      btn_p[2] = ~btn_p[2];
      for (int j = 0; j < 6; j++) begin
        cyc(1);
        if (out_p[2] !== 1'b0) moved = 1'b1;
      end
    end
    chk("R5 quiet during chatter", moved, 1'b0);
    cyc(LAT_P - 1 - 6);
    chk("R5 not yet after last change", out_p[2], 1'b0);
    cyc(1);
    chk("R5 follows final level", out_p[2], 1'b1);
  endtask

  task automatic t_indep();
    logic start2;
    logic moved = 1'b0;
    cyc(LAT_P + 5);
    start2 = out_p[2];
    btn_p[3] = 1'b1;
    btn_p[2] = ~btn_p[2];
    for (int k = 1; k <= LAT_P + 2; k++) begin
      cyc(1);
      if (k == LAT_P - 1) chk("R6 clean channel not yet", out_p[3], 1'b0);
      if (k == LAT_P)     chk("R6 clean channel on time", out_p[3], 1'b1);
      if (out_p[2] !== start2) moved = 1'b1;
      if (k % 4 == 0) btn_p[2] = ~btn_p[2];
    end
    chk("R6 chattering channel held", moved, 1'b0);
  endtask

  task automatic t_timed_step(input logic val);
    cyc(LAT_T + 5);
    btn_t[0] = val;
    cyc(LAT_T - 1);
    chk("R7 timed not yet", out_t[0], ~val);
    cyc(1);
    chk("R7 timed settled", out_t[0], val);
    cyc(2);
    chk("R9 timed holds", out_t[0], val);
  endtask

  task automatic t_timed_restart();
    cyc(LAT_T + 5);
    btn_t[1] = 1'b1;
    cyc(60);
    btn_t[1] = 1'b0;
    cyc(10);
    chk("R8 no early change", out_t[1], 1'b0);
    btn_t[1] = 1'b1;
    cyc(LAT_T - 1);
    chk("R8 full interval re-measured", out_t[1], 1'b0);
    cyc(1);
    chk("R8 settled after restart", out_t[1], 1'b1);
  endtask

  initial begin
    rst_n = 1'b1;
    btn_p = '0;
    btn_t = '0;
    #1 rst_n = 1'b0;
    cyc(3);
    t_reset();
    t_step(0, 1'b1);
    t_step(0, 1'b0);
    t_short_pulse();
    t_bounce();
    t_indep();
    t_timed_step(1'b1);
    t_timed_step(1'b0);
    t_timed_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule